// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the low-order word address for a four-beat burst into a pipelined synchronous SRAM. When the surrounding control logic accepts an address strobe, the sequencer captures the two lowest bits of the presented address as the burst start. From then on, each clock edge where the active-low advance input is asserted moves the burst to its next position. An edge without advance holds the position, so the controller can insert wait states. After the fourth beat the sequence wraps back to the start address rather than stopping.

An ordering select input chooses between two sequences. In linear order the address counts upward modulo four from the start. In interleaved order the address is the start address XOR a beat count. The select is registered, so a change reaches the output one clock edge later. The output is meant to be joined with the registered upper address bits elsewhere. The sequencer does not decode chip enables, hold data or contain the memory array.

Top module: `burst_lo_counter`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, `burst_lo_o` is 0 and the order is linear.
- R2: A rising edge with `strobe_ld_i` high captures `start_lo_i` as the burst base and clears the beat count. From that edge on, `burst_lo_o` equals the base.
- R3: A rising edge with `strobe_ld_i` low and `adv_ni` low (active) advances the beat count by one. With `adv_ni` high, the position holds.
- R4: With `order_sel_i` = 0 (linear), `burst_lo_o` = (base + beat) mod 4. For example, start 1 gives 1, 2, 3, 0.
- R5: With `order_sel_i` = 1 (interleaved), `burst_lo_o` = base XOR beat. For example, start 1 gives 1, 0, 3, 2.
- R6: After four advances the output returns to the start address and the burst continues from there.
- R7: When `strobe_ld_i` and an active `adv_ni` arrive at the same edge, the load wins and the output equals the new start.
- R8: `order_sel_i` is sampled at each rising edge and affects `burst_lo_o` only after that edge. Before the edge the output keeps the old order. A change of order alters neither the base nor the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_ld_i | input | 1 | Accepted address strobe: load start bits |
| start_lo_i | input | 2 | Low address bits presented with the strobe |
| adv_ni | input | 1 | Active-low burst advance |
| order_sel_i | input | 1 | 0 = linear order, 1 = interleaved order |
| burst_lo_o | output | 2 | Current low burst address |

## Verification
Every result of this block (load, advance, hold and the new ordering) reaches `burst_lo_o` at the first rising edge after the stimulus is sampled. No further register lies between the state and the output. The bench drives inputs on the falling edge and samples the output one nanosecond after the next rising edge, so each vector's expected value belongs to exactly one edge. The one-edge latency of the order select is also checked on the other side of the edge: after the select changes at the falling edge, the output is sampled before the rising edge and must still show the old order.

// File: rtl/burst_lo_pkg.sv
package burst_lo_pkg;
  // Width of the burst position: 2 bits gives four beats per burst
  localparam int unsigned LO_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_step_ctr.sv
module burst_step_ctr #(
  parameter int unsigned W = burst_lo_pkg::LO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] start_i,
  input  logic         adv_ni,
  output logic [W-1:0] base_o,
  output logic [W-1:0] beat_o
);
  localparam logic [W-1:0] ONE = W'(1);

  // Named events for the assertions; a load shadows an advance (R7)
  logic ev_load, ev_step, ev_hold;
  assign ev_load = ld_i;
  assign ev_step = !ld_i && !adv_ni;
  assign ev_hold = !ld_i && adv_ni;

  logic [W-1:0] base_q, beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (ev_load) begin
      base_q <= start_i;
      beat_q <= '0;
    end else if (ev_step) begin
      beat_q <= beat_q + ONE;  // wraps naturally after the last beat (R6)
    end
  end

  assign base_o = base_q;
  assign beat_o = beat_q;

  p_load_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_load |=> (base_q == $past(start_i)) && (beat_q == '0));

  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_step |=> (beat_q == $past(beat_q) + ONE) && $stable(base_q));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_hold |=> $stable(beat_q) && $stable(base_q));

  p_load_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_load && !adv_ni) |=> (beat_q == '0));
endmodule

// File: rtl/burst_order_reg.sv
module burst_order_reg
  import burst_lo_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sel_i,
  output order_e order_o
);
  order_e order_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) order_q <= ORD_LINEAR;
    else         order_q <= order_e'(sel_i);
  end

  assign order_o = order_q;

  p_order_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (order_q == order_e'($past(sel_i))));
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import burst_lo_pkg::*;
#(
  parameter int unsigned W = LO_W
) (
  input  order_e       order_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] beat_i,
  output logic [W-1:0] addr_o
);
  function automatic logic [W-1:0] linear_pos(logic [W-1:0] b, logic [W-1:0] k);
    return b + k;
  endfunction

  function automatic logic [W-1:0] interleave_pos(logic [W-1:0] b, logic [W-1:0] k);
    return b ^ k;
  endfunction

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: addr_o = interleave_pos(base_i, beat_i);
      default:        addr_o = linear_pos(base_i, beat_i);
    endcase
  end

  // The first beat is the start address in either order (R2, R6)
  always_comb begin
    if (beat_i == '0) begin
      a_first_beat_r6: assert (addr_o == base_i);
    end
  end
endmodule

// File: rtl/burst_lo_counter.sv
module burst_lo_counter
  import burst_lo_pkg::*;
#(
  parameter int unsigned W = LO_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_ld_i,
  input  logic [W-1:0] start_lo_i,
  input  logic         adv_ni,
  input  logic         order_sel_i,
  output logic [W-1:0] burst_lo_o
);
  logic [W-1:0] base_w, beat_w;
  order_e       order_w;

  burst_step_ctr #(.W(W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ld_i    (strobe_ld_i),
    .start_i (start_lo_i),
    .adv_ni  (adv_ni),
    .base_o  (base_w),
    .beat_o  (beat_w)
  );

  burst_order_reg u_ord (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (order_sel_i),
    .order_o (order_w)
  );

  burst_addr_map #(.W(W)) u_map (
    .order_i (order_w),
    .base_i  (base_w),
    .beat_i  (beat_w),
    .addr_o  (burst_lo_o)
  );

  p_load_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_ld_i |=> (burst_lo_o == $past(start_lo_i)));

  p_hold_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_ld_i && adv_ni && (order_sel_i == order_w)) |=> $stable(burst_lo_o));
endmodule

// File: tb/burst_lo_counter_test.sv
module burst_lo_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld = 1'b0;
  logic [1:0] st = 2'd0;
  logic       advn = 1'b1;
  logic       md = 1'b0;
  logic [1:0] out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  burst_lo_counter uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .strobe_ld_i (ld),
    .start_lo_i  (st),
    .adv_ni      (advn),
    .order_sel_i (md),
    .burst_lo_o  (out)
  );

  // Vector fields: {load, start[1:0], adv_n, mode, expected[1:0]}
  localparam int NV = 20;
  localparam logic [6:0] VEC [NV] = '{
    {1'b1, 2'd1, 1'b1, 1'b0, 2'd1},  // R2 load start 1, linear
    {1'b0, 2'd0, 1'b0, 1'b0, 2'd2},  // R4
    {1'b0, 2'd0, 1'b0, 1'b0, 2'd3},  // R4
    {1'b0, 2'd0, 1'b0, 1'b0, 2'd0},  // R4
    {1'b0, 2'd0, 1'b0, 1'b0, 2'd1},  // R6 wrap to start
    {1'b0, 2'd0, 1'b1, 1'b0, 2'd1},  // R3 hold
    {1'b0, 2'd0, 1'b1, 1'b0, 2'd1},  // R3 hold
    {1'b1, 2'd1, 1'b1, 1'b1, 2'd1},  // R2 load start 1, interleaved
    {1'b0, 2'd0, 1'b0, 1'b1, 2'd0},  // R5
    {1'b0, 2'd0, 1'b0, 1'b1, 2'd3},  // R5
    {1'b0, 2'd0, 1'b0, 1'b1, 2'd2},  // R5
    {1'b0, 2'd0, 1'b0, 1'b1, 2'd1},  // R6 wrap
    {1'b1, 2'd2, 1'b0, 1'b1, 2'd2},  // R7 load beats advance
    {1'b0, 2'd0, 1'b0, 1'b1, 2'd3},  // R5
    {1'b1, 2'd3, 1'b1, 1'b1, 2'd3},  // R2
    {1'b0, 2'd0, 1'b0, 1'b1, 2'd2},  // R5 3^1
    {1'b0, 2'd0, 1'b1, 1'b0, 2'd0},  // R8 switch to linear: 3+1
    {1'b0, 2'd0, 1'b0, 1'b0, 2'd1},  // R8 position kept: 3+2
    {1'b0, 2'd0, 1'b0, 1'b1, 2'd0},  // R8 back to interleaved: 3^3
    {1'b0, 2'd0, 1'b0, 1'b1, 2'd3}   // R6 wrap to start
  };

  task automatic check(input logic [1:0] exp, input string req);
    checks++;
    if (out !== exp) begin
      errors++;
      $display("FAIL %s: burst_lo_o=%0d expected %0d", req, out, exp);
    end
  endtask

  initial begin
    #40000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    #1 check(2'd0, "R1 during reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check(2'd0, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ld   = VEC[i][6];
      st   = VEC[i][5:4];
      advn = VEC[i][3];
      md   = VEC[i][2];
      if (i == 16) begin
        #1 check(2'd2, "R8 old order kept before edge");
      end
      @(posedge clk);
      #1 check(VEC[i][1:0], $sformatf("R2-8 vector %0d", i));
    end

    // R7 directed: load start 0 with advance in linear order
    @(negedge clk); ld = 1'b1; st = 2'd0; advn = 1'b0; md = 1'b0;
    @(posedge clk); #1 check(2'd0, "R7 load over advance");
    @(negedge clk); ld = 1'b0;
    @(posedge clk); #1 check(2'd1, "R3 advance after load");

    // R1: reset in mid-burst clears the output at once
    @(negedge clk); advn = 1'b1; md = 1'b1; rst_n = 1'b0;
    #1 check(2'd0, "R1 mid-burst reset");
    @(negedge clk); rst_n = 1'b1; md = 1'b0;
    @(posedge clk); #1 check(2'd0, "R1 after second release");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule